// File: doc/BRIEF.md
# Full-Scan Test Application Sequencer

This block runs a stored test set through a full-scan chain of `STATE_W` flip-flops wrapped around a combinational circuit under test. Each test vector has a state part, which is loaded serially into the chain, and a primary-input part, which is driven onto the circuit's inputs. For every vector the sequencer shifts the state part in, then applies the primary inputs and compares the primary outputs with their expected values. It then gives one capture clock with the chain in normal mode. While the next vector shifts in, the captured state shifts out and is compared bit by bit.

Vectors are read through a single-address memory port. The block presents an index, and the memory returns the state part, the primary-input part, the expected next state and the expected primary outputs for that index in the same cycle. Because unload of one vector overlaps load of the next, a run of `NUM_VEC` vectors takes exactly `NUM_VEC*(STATE_W+1)+STATE_W-1` counted cycles. A sticky fail flag and a one-cycle done pulse report the result.

Top module: `scan_test_seq`

## Requirements
- R1: While `rst_ni` is low, and in idle after it, `scan_en_o`=0, `pi_o`=0, `vec_idx_o`=0, `cycle_cnt_o`=0, `done_o`=0 and `fail_o`=0. A reset during a run returns the block to idle at once.
- R2: A `start_i` seen in idle begins a run. For each vector, `scan_en_o`=1 for exactly `STATE_W` cycles. In shift cycle j (j=0 first), `scan_in_o` carries bit `STATE_W-1-j` of the vector's state part. The chain moves scan-in toward scan-out, so bit b of the state part ends in the b-th flop counted from the scan-in end.
- R3: Right after the shift cycles comes exactly one capture cycle: `scan_en_o`=0 and `pi_o` equals the vector's primary-input part. `po_i` is compared with the expected outputs at the end of that cycle.
- R4: `pi_o` is zero in every cycle other than a capture cycle.
- R5: During the shift cycles of vector i>0, `scan_out_i` in shift cycle j is compared with bit `STATE_W-1-j` of vector i-1's expected next state.
- R6: After the last capture come `STATE_W-1` unload cycles with `scan_en_o`=1, compared as in R5. These are followed by one uncounted cycle with `scan_en_o`=0, in which `scan_out_i` is compared with bit 0 of the last expected state.
- R7: When `done_o` is high, `cycle_cnt_o` equals `NUM_VEC*(STATE_W+1)+STATE_W-1`.
- R8: `fail_o` rises after the first mismatch of R3, R5 or R6 and stays high until the next accepted start, which clears it.
- R9: `done_o` is high for exactly one cycle, the cycle after the final scan-out comparison.
- R10: `start_i` has no effect while a run is in progress.
- R11: `vec_idx_o` equals the current vector's index through its shift and capture cycles. It steps by one after each capture and holds `NUM_VEC-1` through unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the scan chain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted in idle only) |
| scan_en_o | output | 1 | Chain mode: 1 shift, 0 normal load |
| scan_in_o | output | 1 | Serial data into the chain |
| scan_out_i | input | 1 | Serial data from the last chain flop |
| pi_o | output | PI_W | Primary inputs of the circuit under test |
| po_i | input | PO_W | Primary outputs of the circuit under test |
| vec_idx_o | output | IDX_W | Vector memory address |
| vec_state_i | input | STATE_W | State part of addressed vector |
| vec_pi_i | input | PI_W | Primary-input part of addressed vector |
| vec_exp_state_i | input | STATE_W | Expected captured state of addressed vector |
| vec_exp_po_i | input | PO_W | Expected primary outputs of addressed vector |
| fail_o | output | 1 | Sticky mismatch flag |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cycle_cnt_o | output | CYC_W | Counted cycles of the current or last run |

## Verification
A wrong bit counter or phase shows up within one vector as a shift window longer or shorter than `STATE_W`. It can also show up as a mis-ordered `scan_in_o` bit or a `pi_o` value outside the capture cycle. All of these are visible at the ports on the cycle they occur. A wrong held copy of the expected state does not show directly. It appears as a false or missed `fail_o` one cycle after the affected scan-out comparison, so the bench corrupts captured bits at the first-observed and last-observed chain positions. A miscounted unload tail changes `cycle_cnt_o` and moves `done_o` by whole cycles at the end of the run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_CAPT,
    PH_UNLOAD,
    PH_FINAL
  } phase_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned BIT_W   = 2,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned CYC_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             have_prev_o,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(STATE_W - 1);
  localparam logic [BIT_W-1:0] UNL_LAST = BIT_W'((STATE_W > 1) ? STATE_W - 2 : 0);
  localparam logic [IDX_W-1:0] VEC_LAST = IDX_W'(NUM_VEC - 1);
  localparam bit               HAS_UNL  = (STATE_W > 1);

  phase_e           phase_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] vec_q;
  logic [CYC_W-1:0] cyc_q;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      vec_q   <= '0;
      cyc_q   <= '0;
      prev_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SHIFT;
            bit_q   <= '0;
            vec_q   <= '0;
            cyc_q   <= '0;
            prev_q  <= 1'b0;
          end
        end
        PH_SHIFT: begin
          cyc_q <= cyc_q + 1'b1;
          if (bit_q == BIT_LAST) phase_q <= PH_CAPT;
          else bit_q <= bit_q + 1'b1;
        end
        PH_CAPT: begin
          cyc_q  <= cyc_q + 1'b1;
          prev_q <= 1'b1;
          bit_q  <= '0;
          if (vec_q == VEC_LAST) begin
            if (HAS_UNL) begin
              phase_q <= PH_UNLOAD;
            end else begin
              phase_q <= PH_FINAL;
              bit_q   <= BIT_LAST;
            end
          end else begin
            vec_q   <= vec_q + 1'b1;
            phase_q <= PH_SHIFT;
          end
        end
        PH_UNLOAD: begin
          cyc_q <= cyc_q + 1'b1;
          if (bit_q == UNL_LAST) begin
            phase_q <= PH_FINAL;
            bit_q   <= BIT_LAST;  // last bit sits at chain end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_FINAL: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign bit_o       = bit_q;
  assign vec_o       = vec_q;
  assign have_prev_o = prev_q;
  assign cyc_o       = cyc_q;
endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PI_W    = 3,
  parameter int unsigned BIT_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             phase_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic [STATE_W-1:0] vec_state_i,
  input  logic [PI_W-1:0]    vec_pi_i,
  input  logic [STATE_W-1:0] vec_exp_state_i,
  output logic               scan_en_o,
  output logic               scan_in_o,
  output logic [PI_W-1:0]    pi_o,
  output logic               exp_bit_o
);
  logic [STATE_W-1:0] state_rev;
  logic [STATE_W-1:0] exp_rev;
  logic [STATE_W-1:0] prev_exp_q;

  // bit order reversal: far end of the chain goes first
  for (genvar g = 0; g < STATE_W; g++) begin : g_rev
    assign state_rev[g] = vec_state_i[STATE_W-1-g];
    assign exp_rev[g]   = prev_exp_q[STATE_W-1-g];
  end

  // expected capture held so the memory needs a single address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prev_exp_q <= '0;
    else if (phase_i == PH_CAPT) prev_exp_q <= vec_exp_state_i;
  end

  assign scan_en_o = (phase_i == PH_SHIFT) || (phase_i == PH_UNLOAD);
  assign scan_in_o = (phase_i == PH_SHIFT) && state_rev[bit_i];
  assign pi_o      = (phase_i == PH_CAPT) ? vec_pi_i : '0;
  assign exp_bit_o = exp_rev[bit_i];
endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp
  import scan_seq_pkg::*;
#(
  parameter int unsigned PO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  phase_e          phase_i,
  input  logic            have_prev_i,
  input  logic            scan_out_i,
  input  logic            exp_bit_i,
  input  logic [PO_W-1:0] po_i,
  input  logic [PO_W-1:0] exp_po_i,
  output logic            fail_o,
  output logic            done_o
);
  logic obs_chain, bad_chain, bad_po;
  logic fail_q, done_q;

  assign obs_chain = ((phase_i == PH_SHIFT) && have_prev_i) ||
                     (phase_i == PH_UNLOAD) || (phase_i == PH_FINAL);
  assign bad_chain = obs_chain && (scan_out_i != exp_bit_i);
  assign bad_po    = (phase_i == PH_CAPT) && (po_i != exp_po_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (phase_i == PH_FINAL);
      if ((phase_i == PH_IDLE) && start_i) fail_q <= 1'b0;
      else if (bad_chain || bad_po)        fail_q <= 1'b1;
    end
  end

  assign fail_o = fail_q;
  assign done_o = done_q;
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PI_W    = 3,
  parameter int unsigned PO_W    = 2,
  parameter int unsigned NUM_VEC = 5,
  localparam int unsigned IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int unsigned TOTAL  = NUM_VEC * (STATE_W + 1) + STATE_W - 1,
  localparam int unsigned CYC_W  = $clog2(TOTAL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               scan_en_o,
  output logic               scan_in_o,
  input  logic               scan_out_i,
  output logic [PI_W-1:0]    pi_o,
  input  logic [PO_W-1:0]    po_i,
  output logic [IDX_W-1:0]   vec_idx_o,
  input  logic [STATE_W-1:0] vec_state_i,
  input  logic [PI_W-1:0]    vec_pi_i,
  input  logic [STATE_W-1:0] vec_exp_state_i,
  input  logic [PO_W-1:0]    vec_exp_po_i,
  output logic               fail_o,
  output logic               done_o,
  output logic [CYC_W-1:0]   cycle_cnt_o
);
  localparam int unsigned BIT_W = (STATE_W > 1) ? $clog2(STATE_W) : 1;

  phase_e           phase;
  logic [BIT_W-1:0] bit_idx;
  logic             have_prev;
  logic             exp_bit;

  scan_seq_ctrl #(
    .STATE_W(STATE_W), .NUM_VEC(NUM_VEC),
    .BIT_W(BIT_W), .IDX_W(IDX_W), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .phase_o    (phase),
    .bit_o      (bit_idx),
    .vec_o      (vec_idx_o),
    .have_prev_o(have_prev),
    .cyc_o      (cycle_cnt_o)
  );

  scan_seq_dp #(
    .STATE_W(STATE_W), .PI_W(PI_W), .BIT_W(BIT_W)
  ) u_dp (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .phase_i        (phase),
    .bit_i          (bit_idx),
    .vec_state_i    (vec_state_i),
    .vec_pi_i       (vec_pi_i),
    .vec_exp_state_i(vec_exp_state_i),
    .scan_en_o      (scan_en_o),
    .scan_in_o      (scan_in_o),
    .pi_o           (pi_o),
    .exp_bit_o      (exp_bit)
  );

  scan_seq_cmp #(
    .PO_W(PO_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .phase_i    (phase),
    .have_prev_i(have_prev),
    .scan_out_i (scan_out_i),
    .exp_bit_i  (exp_bit),
    .po_i       (po_i),
    .exp_po_i   (vec_exp_po_i),
    .fail_o     (fail_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PI_W    = 3,
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned CYC_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             scan_en_o,
  input logic [PI_W-1:0]  pi_o,
  input logic [IDX_W-1:0] vec_idx_o,
  input logic             fail_o,
  input logic             done_o,
  input logic [CYC_W-1:0] cycle_cnt_o
);
  localparam int unsigned TOTAL = NUM_VEC * (STATE_W + 1) + STATE_W - 1;
  localparam int unsigned RUN_W = $clog2(STATE_W + 2);

  logic [RUN_W-1:0] run_q;  // shift cycles seen before this one

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (scan_en_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  a_r2_shift_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> (run_q < RUN_W'(STATE_W)));

  a_r3_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pi_o != '0) |=> (pi_o == '0));

  a_r4_pi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> (pi_o == '0));

  a_r7_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycle_cnt_o == CYC_W'(TOTAL)));

  a_r8_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r1_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scan_en_o && (pi_o == '0)));

  a_r11_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_idx_o <= IDX_W'(NUM_VEC - 1));
endmodule

bind scan_test_seq scan_test_seq_chk #(
  .STATE_W(STATE_W), .PI_W(PI_W), .NUM_VEC(NUM_VEC),
  .IDX_W(IDX_W), .CYC_W(CYC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .scan_en_o  (scan_en_o),
  .pi_o       (pi_o),
  .vec_idx_o  (vec_idx_o),
  .fail_o     (fail_o),
  .done_o     (done_o),
  .cycle_cnt_o(cycle_cnt_o)
);

// File: tb/scan_test_seq_tb.sv
`timescale 1ns/1ps
module scan_test_seq_tb;
  localparam int K = 4, L = 3, M = 2, N = 5;
  localparam int TOTAL = N * (K + 1) + K - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scan_en, scan_in, scan_out, fail, done;
  logic [L-1:0] pi;
  logic [M-1:0] po;
  logic [2:0] vec_idx;
  logic [K-1:0] vec_state, vec_exp_state;
  logic [L-1:0] vec_pi;
  logic [M-1:0] vec_exp_po;
  logic [4:0] cyc;
  int n_chk = 0, n_bad = 0;

  logic flt_on = 1'b0, flt_po = 1'b0;
  int flt_vec = 0;
  logic [K-1:0] flt_mask = '0;
  logic [K-1:0] chain = '0;

  always #2.5 clk = ~clk;

  function automatic logic [K-1:0] f_state(int i); return K'((i * 5 + 3) % 16); endfunction
  function automatic logic [L-1:0] f_pi(int i); return L'((i * 3 + 1) % 8); endfunction
  function automatic logic [K-1:0] f_ns(logic [K-1:0] s, logic [L-1:0] p);
    return {s[2:0], s[3] ^ p[0]} ^ {p[2:1], 2'b00};
  endfunction
  function automatic logic [M-1:0] f_po(logic [K-1:0] s, logic [L-1:0] p);
    return {s[3] ^ p[1], (^s) ^ p[2]};
  endfunction

  // vector memory and circuit under test with its scan chain
  assign vec_state     = f_state(int'(vec_idx));
  assign vec_pi        = f_pi(int'(vec_idx));
  assign vec_exp_state = f_ns(f_state(int'(vec_idx)), f_pi(int'(vec_idx)));
  assign vec_exp_po    = f_po(f_state(int'(vec_idx)), f_pi(int'(vec_idx)));
  assign scan_out      = chain[K-1];
  assign po = f_po(chain, pi) ^
              {1'b0, flt_po && !scan_en && (int'(vec_idx) == flt_vec)};

  always_ff @(posedge clk) begin
    if (scan_en) chain <= {chain[K-2:0], scan_in};
    else chain <= f_ns(chain, pi) ^
                  ((flt_on && int'(vec_idx) == flt_vec) ? flt_mask : '0);
  end

  scan_test_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .scan_en_o(scan_en), .scan_in_o(scan_in), .scan_out_i(scan_out),
    .pi_o(pi), .po_i(po), .vec_idx_o(vec_idx),
    .vec_state_i(vec_state), .vec_pi_i(vec_pi),
    .vec_exp_state_i(vec_exp_state), .vec_exp_po_i(vec_exp_po),
    .fail_o(fail), .done_o(done), .cycle_cnt_o(cyc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one full run; per-cycle protocol errors are gathered per requirement
  task automatic run_test(input bit f_state_on, input int f_vec, input logic [K-1:0] f_mask,
                          input bit f_po_on, input bit poke, input bit exp_fail, input string tag);
    int e2 = 0, e3 = 0, e4 = 0, e6 = 0, e11 = 0;
    flt_on = f_state_on; flt_vec = f_vec; flt_mask = f_mask; flt_po = f_po_on;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(fail == 1'b0, {tag, " R8 clear on start"}, fail, 0);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < K; j++) begin
        if (i > 0 || j > 0) @(negedge clk);
        start = poke && (i == 2) && (j == 1);  // R10 start mid-run
        if (!scan_en || scan_in != f_state(i)[K-1-j]) e2++;
        if (pi != '0) e4++;
        if (int'(vec_idx) != i) e11++;
      end
      @(negedge clk);
      start = 1'b0;
      if (scan_en || pi != f_pi(i)) e3++;
      if (int'(vec_idx) != i) e11++;
    end
    for (int u = 0; u < K - 1; u++) begin
      @(negedge clk);
      if (!scan_en || pi != '0 || done) e6++;
      if (int'(vec_idx) != N - 1) e11++;
    end
    @(negedge clk);
    if (scan_en || done) e6++;
    @(negedge clk);
    chk(e2 == 0, {tag, " R2 shift window/order"}, e2, 0);
    chk(e3 == 0, {tag, " R3 capture cycle"}, e3, 0);
    chk(e4 == 0, {tag, " R4 pi quiet"}, e4, 0);
    chk(e6 == 0, {tag, " R6 unload tail"}, e6, 0);
    chk(e11 == 0, {tag, " R11 vector index"}, e11, 0);
    chk(done == 1'b1, {tag, " R9 done"}, done, 1);
    chk(int'(cyc) == TOTAL, {tag, " R7 cycle total"}, cyc, TOTAL);
    chk(fail == exp_fail, {tag, " R5/R8 fail result"}, fail, exp_fail);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 pulse width"}, done, 0);
  endtask

  task automatic t_reset();
    chk(scan_en == 0 && pi == '0 && vec_idx == '0, "R1 reset outputs", scan_en, 0);
    chk(cyc == '0 && done == 0 && fail == 0, "R1 reset status", cyc, 0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(scan_en == 0 && vec_idx == '0 && cyc == '0, "R1 mid-run reset", vec_idx, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(scan_en == 0 && done == 0 && pi == '0, "R1 idle after reset", scan_en, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_test(0, 0, '0, 0, 0, 0, "clean");
    run_test(1, 0, 4'b1000, 0, 0, 1, "R5 first-bit fault");
    run_test(0, 0, '0, 0, 0, 0, "R8 clear run");
    run_test(1, N - 1, 4'b0001, 0, 0, 1, "R6 last-bit fault");
    run_test(1, 1, 4'b0100, 0, 0, 1, "R5 mid-bit fault");
    run_test(0, 2, '0, 1, 0, 1, "R3 po fault");
    run_test(0, 0, '0, 0, 1, 0, "R10 start ignored");
    t_mid_reset();
    run_test(0, 0, '0, 0, 0, 0, "after reset");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule